// File: doc/BRIEF.md
# PI Loop Filter for a Grid-Synchronising Digital PLL

This block is the proportional-integral stage of an all-digital three-phase phase-locked loop. Each sample period, a strobe delivers the decoupled q-axis voltage error as a signed Q15 word. The block forms a proportional term and an integral increment from that error in the same cycle. It adds the increment to a clamped integrator. It then sums the nominal grid angular frequency, the proportional term and the integrator into a frequency estimate in rad/s, which is output as signed Q16.

All gains are fixed-point parameters scaled by 2^16. `KP_Q` defaults to about 155.48, which is 1.414·35π. `KIT_Q` is the pre-multiplied product T·Ki. With T = 0.2 ms and Ki = (35π)², it defaults to about 2.418. `W0_Q` is 100π rad/s. The integrator clamp `LIM_Q` defaults to 1000 rad/s. Because of that clamp, no internal sum can wrap.

A four-state sequencer drives the work:

- **ST_IDLE**: waits for the strobe and latches the error. Transition: strobe high → ST_MULT.
- **ST_MULT**: registers both scaled products. Transition: always → ST_ACCUM.
- **ST_ACCUM**: updates the integrator. Transition: always → ST_EMIT.
- **ST_EMIT**: registers the output and raises the valid pulse. Transition: always → ST_IDLE.

Top module: `pi_loop_filter`

## Requirements
- R1: While synchronous reset is high, and at the first edge after it, `omega_o` equals `W0_Q`, `valid_o` is 0 and the integrator holds 0.
- R2: A strobe sampled high at a clock edge while the block is idle is accepted. `valid_o` is high for exactly one cycle, following the third edge after the accepting edge, and `omega_o` changes at that same edge.
- R3: Each accepted sample adds floor(err·KIT_Q / 2^15) to the integrator, exactly once. The integrator does not change at any other time.
- R4: The integrator is clamped to the range [−LIM_Q, +LIM_Q], so no sustained error can make it wrap.
- R5: The proportional term is floor(err·KP_Q / 2^15). It applies only to the current sample and is never accumulated.
- R6: The output is `omega_o` = W0_Q + proportional term + the updated integrator, as signed Q16 in rad/s.
- R7: A strobe that arrives while a sample is in progress (ST_MULT, ST_ACCUM or ST_EMIT) is ignored. `omega_o` holds its value between results.
- R8: `err_i` is read as signed two's-complement Q15 over its full range. This includes −32768, which stands for −1.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Sample strobe, one per sample period |
| err_i | input | 16 | q-axis error, signed Q15 |
| omega_o | output | 32 | Estimated angular frequency, signed Q16 rad/s |
| valid_o | output | 1 | One-cycle pulse when `omega_o` is updated |

## Verification
The hardest state to reach is the integrator clamp. At full-scale error, each sample moves the integrator by only about 2.4 rad/s, so the clamp at 1000 rad/s is more than four hundred samples away. The stimulus holds the strobe high with +32767 error until the positive limit is reached. It then drives −32768 long enough to swing to the negative limit. This also exercises dropped strobes, because the strobe stays high during busy cycles. A behavioural model, which keeps an unbounded integer integrator and applies the clamp as its own rule, is compared with both outputs on every cycle.

// File: rtl/pi_lf_pkg.sv
package pi_lf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MULT,
        ST_ACCUM,
        ST_EMIT
    } lf_state_t;
endpackage

// File: rtl/pi_mul_shift.sv
module pi_mul_shift #(
    parameter int IN_W  = 16,
    parameter int K_W   = 32,
    parameter int OUT_W = 32,
    parameter int SHIFT = 15,
    parameter logic signed [K_W-1:0] K = '0
) (
    input  logic signed [IN_W-1:0]  a_i,
    output logic signed [OUT_W-1:0] y_o
);
    localparam int PROD_W = IN_W + K_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;

    always_comb begin
        prod   = PROD_W'(a_i) * PROD_W'(K);
        scaled = prod >>> SHIFT;
        y_o    = scaled[OUT_W-1:0];
    end
endmodule

// File: rtl/pi_integrator.sv
module pi_integrator #(
    parameter int W = 32,
    parameter logic signed [W-1:0] LIM = 32'sd65536000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  logic signed [W-1:0] inc_i,
    output logic signed [W-1:0] acc_o
);
    localparam logic signed [W:0] HI = {LIM[W-1], LIM};
    localparam logic signed [W:0] LO = -HI;

    logic signed [W:0] wide_sum;

    always_comb wide_sum = {acc_o[W-1], acc_o} + {inc_i[W-1], inc_i};

    always_ff @(posedge clk) begin
        if (rst)
            acc_o <= '0;
        else if (en_i) begin
            if (wide_sum > HI)
                acc_o <= LIM;
            else if (wide_sum < LO)
                acc_o <= -LIM;
            else
                acc_o <= wide_sum[W-1:0];
        end
    end

    // R3: integrator holds when not enabled
    assert_acc_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(acc_o));

    // R4: integrator never leaves the clamp window
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_o <= LIM) && (acc_o >= -LIM));
endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter
    import pi_lf_pkg::*;
#(
    parameter int ERR_W  = 16,
    parameter int ERR_FR = 15,
    parameter int GAIN_W = 32,
    parameter int OUT_W  = 32,
    parameter logic signed [GAIN_W-1:0] KP_Q  = 32'sd10189367,
    parameter logic signed [GAIN_W-1:0] KIT_Q = 32'sd158470,
    parameter logic signed [OUT_W-1:0]  W0_Q  = 32'sd20588742,
    parameter logic signed [OUT_W-1:0]  LIM_Q = 32'sd65536000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    strobe_i,
    input  logic signed [ERR_W-1:0] err_i,
    output logic signed [OUT_W-1:0] omega_o,
    output logic                    valid_o
);
    lf_state_t state, state_nx;

    logic signed [ERR_W-1:0] err_r;
    logic signed [OUT_W-1:0] p_term, i_inc;
    logic signed [OUT_W-1:0] p_r, inc_r;
    logic signed [OUT_W-1:0] acc;

    // proportional and integral products, computed in parallel
    pi_mul_shift #(.IN_W(ERR_W), .K_W(GAIN_W), .OUT_W(OUT_W), .SHIFT(ERR_FR), .K(KP_Q))
        u_prop (.a_i(err_r), .y_o(p_term));
    pi_mul_shift #(.IN_W(ERR_W), .K_W(GAIN_W), .OUT_W(OUT_W), .SHIFT(ERR_FR), .K(KIT_Q))
        u_intg (.a_i(err_r), .y_o(i_inc));

    pi_integrator #(.W(OUT_W), .LIM(LIM_Q)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .en_i  (state == ST_ACCUM),
        .inc_i (inc_r),
        .acc_o (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (strobe_i) state_nx = ST_MULT;
            ST_MULT:  state_nx = ST_ACCUM;
            ST_ACCUM: state_nx = ST_EMIT;
            ST_EMIT:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_r   <= '0;
            p_r     <= '0;
            inc_r   <= '0;
            omega_o <= W0_Q;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            unique case (state)
                ST_IDLE:  if (strobe_i) err_r <= err_i;
                ST_MULT: begin
                    p_r   <= p_term;
                    inc_r <= i_inc;
                end
                ST_ACCUM: ;
                ST_EMIT: begin
                    omega_o <= W0_Q + p_r + acc;
                    valid_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R2: result pulse lasts one cycle
    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R7: output holds between results
    assert_omega_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(omega_o));

    // R7: strobe during a busy sample does not restart the sequence
    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MULT) |=> (state == ST_ACCUM));
endmodule

// File: tb/test_pi_loop_filter.sv
module test_pi_loop_filter;
    localparam longint KP  = 10189367;
    localparam longint KIT = 158470;
    localparam longint W0  = 20588742;
    localparam longint LIM = 65536000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strobe_i = 1'b0;
    logic signed [15:0] err_i = '0;
    logic signed [31:0] omega_o;
    logic valid_o;

    int checks = 0;
    int errors = 0;

    pi_loop_filter i_pi_loop_filter (
        .clk(clk), .rst(rst), .strobe_i(strobe_i), .err_i(err_i),
        .omega_o(omega_o), .valid_o(valid_o)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    longint m_acc = 0;
    longint m_omega = W0;
    longint pend_omega = 0;
    logic   m_valid = 1'b0;
    int     busy = 0;
    int     results = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_acc = 0; m_omega = W0; m_valid = 1'b0; busy = 0;
        end else begin
            m_valid = 1'b0;
            if (busy > 0) begin
                busy = busy - 1;
                if (busy == 0) begin
                    m_omega = pend_omega; m_valid = 1'b1; results++;
                end
            end else if (strobe_i) begin
                longint e;
                e = longint'(err_i);
                m_acc = m_acc + ((e * KIT) >>> 15);
                if (m_acc > LIM) m_acc = LIM;
                if (m_acc < -LIM) m_acc = -LIM;
                pend_omega = W0 + ((e * KP) >>> 15) + m_acc;
                busy = 3;
            end
        end
    end

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // every-cycle comparison (R2 timing, R6 value, R7 hold)
    always @(negedge clk) begin
        if (!rst) begin
            check("R2", valid_o == m_valid, longint'(valid_o), longint'(m_valid));
            check("R6", longint'(omega_o) == m_omega, longint'(omega_o), m_omega);
        end
    end

    task automatic sample(input logic signed [15:0] e);
        @(negedge clk); strobe_i = 1'b1; err_i = e;
        @(negedge clk); strobe_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=done");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", longint'(omega_o) == W0, longint'(omega_o), W0);
        check("R1", valid_o == 1'b0, longint'(valid_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", longint'(omega_o) == W0, longint'(omega_o), W0);

        // R1/R5/R3: first sample from a clear integrator
        sample(16'sd16384);
        check("R5", longint'(omega_o) == W0 + ((16384 * KP) >>> 15) + ((16384 * KIT) >>> 15),
              longint'(omega_o), W0 + ((16384 * KP) >>> 15) + ((16384 * KIT) >>> 15));
        // R3/R5: zero error leaves only integrator contribution
        sample(16'sd0);
        check("R3", longint'(omega_o) == W0 + ((16384 * KIT) >>> 15),
              longint'(omega_o), W0 + ((16384 * KIT) >>> 15));
        // R8: negative and full-scale values
        sample(-16'sd1);
        sample(-16'sd32768);
        sample(16'sd32767);
        sample(16'sd1234);
        sample(-16'sd9876);

        // R7: strobe held high, busy strobes dropped
        @(negedge clk); strobe_i = 1'b1; err_i = 16'sd32767;
        begin
            int start;
            start = results;
            repeat (40) @(negedge clk);
            check("R7", (results - start) == 10, longint'(results - start), 10);
        end

        // R4: drive to positive clamp
        repeat (2000) @(negedge clk);
        strobe_i = 1'b0; repeat (5) @(negedge clk);
        check("R4", m_acc == LIM, m_acc, LIM);
        sample(16'sd0);
        check("R4", longint'(omega_o) == W0 + LIM, longint'(omega_o), W0 + LIM);

        // R4/R8: swing to negative clamp with -1.0
        @(negedge clk); strobe_i = 1'b1; err_i = -16'sd32768;
        repeat (3600) @(negedge clk);
        strobe_i = 1'b0; repeat (5) @(negedge clk);
        sample(16'sd0);
        check("R4", longint'(omega_o) == W0 - LIM, longint'(omega_o), W0 - LIM);

        // R1: reset mid-life clears integrator
        @(negedge clk); rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
        sample(16'sd0);
        check("R1", longint'(omega_o) == W0, longint'(omega_o), W0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule